// File: doc/BRIEF.md
# Hopping NCO with Timed Start and Frequency-Hop Hold-Off

This block is the phase generator for a single receive channel. A 32-bit accumulator adds the active tuning word on every clock while the channel runs. The output frequency is therefore the tuning word divided by 2^32, times the clock rate. The top bits of the phase address a small sine/cosine table, and a registered quadrature pair comes out two clocks later. The block can also add phase dither and amplitude dither, and a bypass mode freezes the accumulator and holds the output at the 0 Hz point.

Software never writes the tuning word directly. It writes a staging word, and a hop sync pulse starts a programmable countdown. When the countdown ends, the staging word becomes the active word. A control bit selects what a hop does to the phase: either the phase continues, or it is reloaded with the programmed offset. A start sync pulse reloads the phase with the offset, stops the channel, and starts a second countdown. The channel runs once that countdown ends. Both countdowns restart if their sync pulse arrives again while they are still counting.

Top module: `hop_nco`

## Requirements
- R1: While `running` is 1 and bypass is off, `phase_out` grows by the active tuning word, modulo 2^32, on every clock with no load.
- R2: A start sync stops the channel and puts the 16-bit offset into `phase_out[31:16]`, with zeros below, at the same edge. With start hold-off H, `running` rises at the (H+1)-th clock edge after the sync edge, and the phase first advances one edge later.
- R3: A hop sync with hop hold-off H copies the staging word into the active word at the (H+1)-th edge after the sync edge. At that edge the accumulator still adds the old word, and the new word applies from the next edge on.
- R4: With control bit 1 (clear-on-hop) set, the edge that applies a hop also reloads the phase with the aligned offset. With the bit clear, the phase only keeps accumulating.
- R5: A sync pulse that arrives while its own countdown is running restarts that countdown from the current hold-off value.
- R6: With control bit 0 (bypass) set, the accumulator holds its value, apart from sync loads. From the second edge after the setting, `cos_out` is 2047 and `sin_out` is 0.
- R7: With dither off, the outputs after edge n are round(2047·cos) and round(2047·sin) of 2π·a/256, where a is `phase_out[31:24]` as held after edge n−2. Rounding is to the nearest integer with the magnitude rounded.
- R8: With control bit 2 (phase dither) set, a 16-bit maximal-length pseudo-random value is added at phase bits 23:8 before the table lookup, so the address is a or a+1 mod 256.
- R9: With control bit 3 (amplitude dither) set, one pseudo-random bit may invert the LSB of both outputs together. With the bit clear, the outputs are exact.
- R10: The write port decodes `wr_addr`: 0 is control, 1 is start hold-off, 2 is hop hold-off, 3 is the staging tuning word, and 4 is the phase offset. After reset, `running` is 0, `phase_out` is 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| start_sync | input | 1 | Channel start pulse |
| hop_sync | input | 1 | Frequency hop pulse |
| running | output | 1 | Channel is running |
| phase_out | output | 32 | Phase accumulator |
| cos_out | output | 12 | Cosine sample, signed |
| sin_out | output | 12 | Sine sample, signed |

## Verification
The bench counts edges exactly around both countdowns and checks the hop edge itself. A design that was off by one on the hold-off would raise `running` or change the slope a cycle early or late. A design that applied the new word at the hop edge would show the wrong phase at that edge. A second start pulse sent mid-countdown catches a counter that does not reload. A clear-on-hop hop catches a design that ignores the offset reload. A scoreboard checks every output sample against an independently computed trigonometric value two cycles back. In bypass, a moving accumulator or a non-full-scale cosine would show as a miscompare. With dither on, the check accepts only the neighbouring address or an LSB toggle.

// File: rtl/hop_nco_pkg.sv
package hop_nco_pkg;

   typedef enum logic [2:0] {
      RA_CTRL       = 3'd0,
      RA_START_HOLD = 3'd1,
      RA_HOP_HOLD   = 3'd2,
      RA_TUNE       = 3'd3,
      RA_OFFSET     = 3'd4
   } nco_reg_e;

   // packed: bypass lands in bit 0, amp_dith in bit 3
   typedef struct packed {
      logic amp_dith;
      logic ph_dith;
      logic clr_hop;
      logic bypass;
   } nco_ctrl_t;

   // Galois feedback masks for a few maximal-length widths
   function automatic logic [31:0] lfsr_taps(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         32:      return 32'h8020_0003;
         default: return 32'h0;
      endcase
   endfunction

   // table entry: round(full * sin(2*pi*idx/2^aw)), symmetric rounding
   function automatic int sine_code(input int idx, input int aw, input int amp_w);
      int depth;
      int qtr;
      int i;
      int k;
      int sgn;
      int mag;
      real x;
      real t;
      real s;
      depth = 1 << aw;
      qtr   = depth / 4;
      i     = idx % depth;
      if (i <= qtr) begin
         k = i; sgn = 1;
      end else if (i <= 2 * qtr) begin
         k = 2 * qtr - i; sgn = 1;
      end else if (i <= 3 * qtr) begin
         k = i - 2 * qtr; sgn = -1;
      end else begin
         k = depth - i; sgn = -1;
      end
      x = 3.14159265358979324 * real'(k) / (2.0 * real'(qtr));
      t = x;
      s = x;
      for (int n = 1; n <= 8; n++) begin
         t = -t * x * x / (real'(2 * n) * real'(2 * n + 1));
         s = s + t;
      end
      mag = $rtoi(s * real'((1 << (amp_w - 1)) - 1) + 0.5);
      return sgn * mag;
   endfunction

endpackage

// File: rtl/nco_holdoff.sv
module nco_holdoff #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   output logic             fire
);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         cnt_q  <= value;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign fire = busy_q && (cnt_q == '0) && !load;

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy_q && cnt_q == $past(value));

   // R3
   fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !busy_q);

endmodule

// File: rtl/nco_lfsr.sv
module nco_lfsr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   import hop_nco_pkg::*;

   localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

   generate
      if (TAPS == '0) begin : g_bad_width
         $fatal(1, "nco_lfsr: unsupported width");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) state <= W'(1);
      else        state <= (state >> 1) ^ (state[0] ? TAPS : '0);
   end

   // R8
   lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
   parameter int ADDR_W = 8,
   parameter int AMP_W  = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [AMP_W-1:0]  sin_o,
   output logic [AMP_W-1:0]  cos_o
);
   import hop_nco_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] QTR = ADDR_W'(DEPTH / 4);

   logic [AMP_W-1:0] tab [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         localparam int V = sine_code(i, ADDR_W, AMP_W);
         assign tab[i] = AMP_W'(V);
      end
   endgenerate

   logic [ADDR_W-1:0] cos_addr;
   assign cos_addr = addr + QTR;
   assign sin_o    = tab[addr];
   assign cos_o    = tab[cos_addr];

endmodule

// File: rtl/hop_nco.sv
module hop_nco #(
   parameter int ACC_W  = 32,
   parameter int OFS_W  = 16,
   parameter int HOLD_W = 16,
   parameter int ADDR_W = 8,
   parameter int AMP_W  = 12,
   parameter int LFSR_W = 16,
   parameter int REG_AW = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [REG_AW-1:0]       wr_addr,
   input  logic [ACC_W-1:0]        wr_data,
   input  logic                    start_sync,
   input  logic                    hop_sync,
   output logic                    running,
   output logic [ACC_W-1:0]        phase_out,
   output logic signed [AMP_W-1:0] cos_out,
   output logic signed [AMP_W-1:0] sin_out
);
   import hop_nco_pkg::*;

   localparam int LOW_W  = ACC_W - ADDR_W;
   localparam int DITH_SH = LOW_W - LFSR_W;
   localparam logic [AMP_W-1:0] FULL = AMP_W'((1 << (AMP_W - 1)) - 1);

   generate
      if (OFS_W > ACC_W || HOLD_W > ACC_W) begin : g_bad_fields
         $fatal(1, "hop_nco: field wider than data word");
      end
      if (DITH_SH < 0) begin : g_bad_dither
         $fatal(1, "hop_nco: dither does not fit below table address");
      end
      if (REG_AW < 3) begin : g_bad_regaw
         $fatal(1, "hop_nco: register address too narrow");
      end
   endgenerate

   // register file
   nco_ctrl_t          ctrl_q;
   logic [HOLD_W-1:0]  start_hold_q;
   logic [HOLD_W-1:0]  hop_hold_q;
   logic [ACC_W-1:0]   stage_q;
   logic [ACC_W-1:0]   act_q;
   logic [OFS_W-1:0]   ofs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q       <= '0;
         start_hold_q <= '0;
         hop_hold_q   <= '0;
         stage_q      <= '0;
         ofs_q        <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_AW'(RA_CTRL):       ctrl_q       <= nco_ctrl_t'(wr_data[3:0]);
            REG_AW'(RA_START_HOLD): start_hold_q <= wr_data[HOLD_W-1:0];
            REG_AW'(RA_HOP_HOLD):   hop_hold_q   <= wr_data[HOLD_W-1:0];
            REG_AW'(RA_TUNE):       stage_q      <= wr_data;
            REG_AW'(RA_OFFSET):     ofs_q        <= wr_data[OFS_W-1:0];
            default: ;
         endcase
      end
   end

   // countdowns
   logic start_fire;
   logic hop_fire;

   nco_holdoff #(.CNT_W(HOLD_W)) u_start_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_sync),
      .value (start_hold_q),
      .fire  (start_fire)
   );

   nco_holdoff #(.CNT_W(HOLD_W)) u_hop_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hop_sync),
      .value (hop_hold_q),
      .fire  (hop_fire)
   );

   // channel state and accumulator
   logic             run_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] ofs_ext;

   assign ofs_ext = {ofs_q, {(ACC_W - OFS_W){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else if (start_sync) run_q <= 1'b0;
      else if (start_fire) run_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= '0;
      else if (hop_fire) act_q <= stage_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          acc_q <= '0;
      else if (start_sync)                 acc_q <= ofs_ext;
      else if (hop_fire && ctrl_q.clr_hop) acc_q <= ofs_ext;
      else if (run_q && !ctrl_q.bypass)    acc_q <= acc_q + act_q;
   end

   assign running   = run_q;
   assign phase_out = acc_q;

   // dither source
   logic [LFSR_W-1:0] lfsr;

   nco_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr)
   );

   // stage 1: dithered address
   logic [ACC_W-1:0]  dith_word;
   logic [ACC_W-1:0]  dith_sum;
   logic [LOW_W-1:0]  dith_unused;
   logic [ADDR_W-1:0] addr_s1;
   logic              byp_s1;
   logic              amp_s1;

   assign dith_word   = ctrl_q.ph_dith ? (ACC_W'(lfsr) << DITH_SH) : '0;
   assign dith_sum    = acc_q + dith_word;
   assign dith_unused = dith_sum[LOW_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_s1 <= '0;
         byp_s1  <= 1'b0;
         amp_s1  <= 1'b0;
      end else begin
         addr_s1 <= dith_sum[ACC_W-1 -: ADDR_W];
         byp_s1  <= ctrl_q.bypass;
         amp_s1  <= ctrl_q.amp_dith & lfsr[0];
      end
   end

   // stage 2: table and output register
   logic [AMP_W-1:0] rom_sin;
   logic [AMP_W-1:0] rom_cos;
   logic [AMP_W-1:0] lsb_flip;

   nco_sincos_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
      .addr  (addr_s1),
      .sin_o (rom_sin),
      .cos_o (rom_cos)
   );

   assign lsb_flip = {{(AMP_W - 1){1'b0}}, amp_s1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cos_out <= '0;
         sin_out <= '0;
      end else if (byp_s1) begin
         cos_out <= FULL;
         sin_out <= '0;
      end else begin
         cos_out <= rom_cos ^ lsb_flip;
         sin_out <= rom_sin ^ lsb_flip;
      end
   end

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_sync |=> !running && phase_out == {$past(ofs_q), {(ACC_W - OFS_W){1'b0}}});

   // R2
   run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(start_fire));

   // R3
   hop_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hop_fire |=> act_q == $past(stage_q));

   // R6
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.bypass && !start_sync && !hop_fire |=> $stable(phase_out));

   // R6
   bypass_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byp_s1 |=> cos_out == FULL && sin_out == '0);

endmodule

// File: tb/sim_hop_nco.sv
module sim_hop_nco;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        start_sync = 1'b0;
   logic        hop_sync = 1'b0;
   logic        running;
   logic [31:0] phase_out;
   logic signed [11:0] cos_out;
   logic signed [11:0] sin_out;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   hop_nco u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .start_sync (start_sync),
      .hop_sync   (hop_sync),
      .running    (running),
      .phase_out  (phase_out),
      .cos_out    (cos_out),
      .sin_out    (sin_out)
   );

   // control bits: [0] bypass, [1] clear-on-hop, [2] phase dither, [3] amp dither
   logic [3:0] m_ctrl = '0;
   bit         mon_on = 1'b0;

   typedef struct {
      logic [7:0] a;
      logic [3:0] c;
   } item_t;
   item_t sb[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] ref_val(input logic [7:0] a, input bit is_cos);
      real v;
      int  r;
      v = 2.0 * 3.14159265358979324 * real'(a) / 256.0;
      v = 2047.0 * (is_cos ? $cos(v) : $sin(v));
      r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
      return 12'(r);
   endfunction

   function automatic bit pair_ok(input logic [7:0] a, input bit amp,
                                  input logic [11:0] c, input logic [11:0] s);
      logic [11:0] ec;
      logic [11:0] es;
      ec = ref_val(a, 1'b1);
      es = ref_val(a, 1'b0);
      if (c == ec && s == es) return 1'b1;
      if (amp && c == (ec ^ 12'd1) && s == (es ^ 12'd1)) return 1'b1;
      return 1'b0;
   endfunction

   // scoreboard monitor: outputs lag the sampled phase by two cycles
   always @(negedge clk) begin
      if (!mon_on) begin
         sb.delete();
      end else begin
         if (sb.size() == 2) begin
            item_t it;
            bit    ok;
            string tag;
            it = sb.pop_front();
            if (it.c[0]) begin
               ok  = (cos_out == 12'sd2047) && (sin_out == 12'sd0);
               tag = "R6 bypass output";
            end else begin
               ok = pair_ok(it.a, it.c[3], cos_out, sin_out) ||
                    (it.c[2] && pair_ok(it.a + 8'd1, it.c[3], cos_out, sin_out));
               tag = it.c[2] ? "R8 phase dither" : (it.c[3] ? "R9 amp dither" : "R7 table");
            end
            chk(ok, tag, {cos_out, sin_out},
                {ref_val(it.a, 1'b1), ref_val(it.a, 1'b0)});
         end
         sb.push_back('{a: phase_out[31:24], c: m_ctrl});
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      if (a == 3'd0) m_ctrl = d[3:0];
      #1;
      wr_en = 1'b0;
   endtask

   task automatic pulse_start();
      start_sync = 1'b1;
      step();
      start_sync = 1'b0;
   endtask

   task automatic pulse_hop();
      hop_sync = 1'b1;
      step();
      hop_sync = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] p0;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk(running == 1'b0, "R10 reset running", running, 0);
      chk(phase_out == 32'h0, "R10 reset phase", phase_out, 0);
      chk(cos_out == 0 && sin_out == 0, "R10 reset outputs", {cos_out, sin_out}, 0);
      rst_n = 1'b1;
      step();
      mon_on = 1'b1;

      // R10 register setup, R2 timed start
      wr(3'd4, 32'h0000_4000);
      wr(3'd1, 32'd3);
      wr(3'd3, 32'h0100_0000);
      wr(3'd2, 32'd0);
      wr(3'd0, 32'h0);
      pulse_start();
      chk(running == 1'b0, "R2 stopped at sync", running, 0);
      chk(phase_out == 32'h4000_0000, "R2 offset load", phase_out, 32'h4000_0000);
      for (int i = 1; i <= 4; i++) begin
         step();
         chk(running == (i == 4), "R2 start hold-off", running, (i == 4));
      end
      chk(phase_out == 32'h4000_0000, "R2 phase held", phase_out, 32'h4000_0000);

      // R3 hop countdown H=2
      wr(3'd2, 32'd2);
      pulse_hop();
      step(); step();
      chk(phase_out == 32'h4000_0000, "R3 before hop", phase_out, 32'h4000_0000);
      step();
      chk(phase_out == 32'h4000_0000, "R3 hop edge uses old word", phase_out, 32'h4000_0000);
      step();
      chk(phase_out == 32'h4100_0000, "R1 R3 new word", phase_out, 32'h4100_0000);
      step();
      chk(phase_out == 32'h4200_0000, "R1 advance", phase_out, 32'h4200_0000);

      // R4 phase-continuous hop, H=0
      wr(3'd3, 32'h0010_0000);
      wr(3'd2, 32'd0);
      pulse_hop();
      p0 = phase_out;
      step();
      chk(phase_out == p0 + 32'h0100_0000, "R4 continuous hop edge", phase_out, p0 + 32'h0100_0000);
      step();
      chk(phase_out == p0 + 32'h0110_0000, "R4 continuous after hop", phase_out, p0 + 32'h0110_0000);

      // R4 clear-on-hop, H=1
      wr(3'd4, 32'h0000_1234);
      wr(3'd0, 32'h2);
      wr(3'd3, 32'h0200_0000);
      wr(3'd2, 32'd1);
      pulse_hop();
      p0 = phase_out;
      step();
      chk(phase_out == p0 + 32'h0010_0000, "R4 countdown", phase_out, p0 + 32'h0010_0000);
      step();
      chk(phase_out == 32'h1234_0000, "R4 clear-on-hop reload", phase_out, 32'h1234_0000);
      step();
      chk(phase_out == 32'h1434_0000, "R4 after reload", phase_out, 32'h1434_0000);

      // R5 restart of start countdown, H=5
      wr(3'd1, 32'd5);
      pulse_start();
      chk(phase_out == 32'h1234_0000 && !running, "R2 restart load", phase_out, 32'h1234_0000);
      step(); step();
      pulse_start();
      for (int i = 1; i <= 6; i++) begin
         step();
         if (i >= 5)
            chk(running == (i == 6), "R5 restarted countdown", running, (i == 6));
      end
      chk(phase_out == 32'h1234_0000, "R2 no advance before run", phase_out, 32'h1234_0000);
      step();
      chk(phase_out == 32'h1434_0000, "R1 first advance", phase_out, 32'h1434_0000);

      // R6 bypass
      wr(3'd0, 32'h1);
      p0 = phase_out;
      step(); step(); step();
      chk(phase_out == p0, "R6 frozen", phase_out, p0);
      chk(cos_out == 12'sd2047 && sin_out == 12'sd0, "R6 dc output", {cos_out, sin_out}, 32'h7ff000);

      // R7 table, two tuning words
      wr(3'd0, 32'h0);
      wr(3'd3, 32'h0300_0000);
      pulse_hop();
      repeat (300) step();
      wr(3'd3, 32'h00AB_CDEF);
      pulse_hop();
      repeat (300) step();

      // R8, R9 dither modes
      wr(3'd0, 32'h4);
      repeat (300) step();
      wr(3'd0, 32'h8);
      repeat (300) step();
      wr(3'd0, 32'hC);
      repeat (300) step();
      wr(3'd0, 32'h0);
      repeat (50) step();

      mon_on = 1'b0;
      step();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule